// File: doc/BRIEF.md
# Stack Pointer and Register Bank Address Unit

This unit produces the 8-bit internal-RAM addresses that a small processor core needs for two kinds of access: stack traffic and general-purpose register traffic. It holds an 8-bit stack pointer that the sequencer controls through push, pop and direct-load strobes. For the current cycle it drives the address where the stack byte is written or read. A push uses pre-increment, so the byte lands one above the current pointer. A pop uses post-decrement, so the byte is read at the current pointer. After reset the pointer is 07h, which puts the first pushed byte at 08h, just above register bank 0.

In parallel, a combinational path turns a 3-bit register index and a 2-bit bank select into a RAM address inside the lowest 32 bytes. The RAM array and the instruction sequencing sit outside this unit. The sequencer asserts at most one strobe per cycle. If it asserts push and pop together, the unit leaves the pointer unchanged and raises an error flag for that cycle.

Top module: `stk_addr_unit`

## Requirements
- R1: After the asynchronous reset (rst_ni low), sp_o reads 07h.
- R2: In a cycle with push_i high and pop_i and load_i low, stk_addr_o equals sp_o + 1 (mod 256), and sp_o holds that value after the next rising edge. The first push after reset therefore addresses 08h.
- R3: In a cycle with pop_i high and push_i and load_i low, stk_addr_o equals sp_o, and sp_o becomes sp_o − 1 (mod 256) after the next rising edge.
- R4: The pointer wraps modulo 256. A push at FFh addresses 00h and leaves the pointer at 00h. A pop at 00h leaves the pointer at FFh.
- R5: When push_i and pop_i are both high and load_i is low, the pointer is unchanged, stk_addr_o equals sp_o, and push_err_o is 1 in that cycle.
- R6: When load_i is high, sp_o takes load_data_i after the next rising edge, whatever push_i and pop_i are. In that cycle push_err_o is 0.
- R7: reg_addr_o equals bank_sel_i × 8 + reg_idx_i, and bits 7:5 are zero. Bank 0 maps to 00h–07h, bank 1 to 08h–0Fh, bank 2 to 10h–17h and bank 3 to 18h–1Fh.
- R8: With no strobe high, sp_o holds its value and stk_addr_o equals sp_o.
- R9: push_err_o is 0 in every cycle where push_i and pop_i are not both high, or where load_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe (pre-increment) |
| pop_i | input | 1 | Pop strobe (post-decrement) |
| load_i | input | 1 | Direct pointer load, highest priority |
| load_data_i | input | 8 | Value loaded into the pointer |
| reg_idx_i | input | 3 | Register index within a bank |
| bank_sel_i | input | 2 | Register bank select |
| stk_addr_o | output | 8 | Stack RAM address for this cycle |
| reg_addr_o | output | 8 | Register RAM address |
| sp_o | output | 8 | Current stack pointer |
| push_err_o | output | 1 | Push and pop requested together |

## Verification
The assertions check every cycle that the pointer moves by exactly +1, −1, load value or nothing according to the decoded command. They also check that load wins over the other strobes, that the conflict flag matches the push-and-pop condition, that the push address sits one above the pointer, and that register addresses stay below 20h. Only the bench scenarios show the absolute values: the 07h reset value, the first push landing at 08h, wrap-around in both directions at the 00h/FFh boundary, and the full sweep of bank and index to RAM address.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_LOAD = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_op_dec.sv
module stk_op_dec
  import stk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    load_i,
  output stk_op_e op_o,
  output logic    conflict_o
);
  always_comb begin
    conflict_o = 1'b0;
    if (load_i)                op_o = OP_LOAD;
    else if (push_i && pop_i) begin
      op_o       = OP_HOLD;
      conflict_o = 1'b1;
    end
    else if (push_i)           op_o = OP_PUSH;
    else if (pop_i)            op_o = OP_POP;
    else                       op_o = OP_HOLD;
  end

  // R6
  load_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (op_o == OP_LOAD && !conflict_o));
  // R5
  conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !load_i) |-> (conflict_o && op_o == OP_HOLD));
  // R9
  no_false_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i) |-> !conflict_o);
endmodule

// File: rtl/stk_ptr_core.sv
module stk_ptr_core
  import stk_pkg::*;
#(
  parameter int unsigned          PTR_W     = 8,
  parameter logic [PTR_W-1:0]     RESET_VAL = PTR_W'(7)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [PTR_W-1:0] load_data_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] addr_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] sp_q, sp_d, sp_inc, sp_dec;

  assign sp_inc = sp_q + ONE;
  assign sp_dec = sp_q - ONE;

  always_comb begin
    unique case (op_i)
      OP_PUSH: sp_d = sp_inc;
      OP_POP:  sp_d = sp_dec;
      OP_LOAD: sp_d = load_data_i;
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= RESET_VAL;
    else         sp_q <= sp_d;
  end

  // pre-increment on push, post-decrement on pop
  assign addr_o = (op_i == OP_PUSH) ? sp_inc : sp_q;
  assign sp_o   = sp_q;

  // R2
  push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH) |=> (sp_q == PTR_W'($past(sp_q) + ONE)));
  // R3
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP) |=> (sp_q == PTR_W'($past(sp_q) - ONE)));
  // R6
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (sp_q == $past(load_data_i)));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(sp_q));
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned USED_W = IDX_W + BANK_W;
  localparam int unsigned PAD_W  = ADDR_W - USED_W;

  generate
    if (PAD_W == 0) begin : g_nopad
      assign addr_o = {bank_i, idx_i};
    end else begin : g_pad
      assign addr_o = {{PAD_W{1'b0}}, bank_i, idx_i};
    end
  endgenerate

  // R7
  reg_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o >> USED_W) == '0);
  // R7
  reg_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[IDX_W-1:0] == idx_i));
endmodule

// File: rtl/stk_addr_unit.sv
module stk_addr_unit
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned BANK_W = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = ADDR_W'(7)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_data_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              push_err_o
);
  stk_op_e op;

  stk_op_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .load_i     (load_i),
    .op_o       (op),
    .conflict_o (push_err_o)
  );

  stk_ptr_core #(
    .PTR_W     (ADDR_W),
    .RESET_VAL (SP_RESET)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .load_data_i (load_data_i),
    .sp_o        (sp_o),
    .addr_o      (stk_addr_o)
  );

  bank_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .BANK_W (BANK_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (reg_idx_i),
    .bank_i (bank_sel_i),
    .addr_o (reg_addr_o)
  );

  // R2
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !load_i) |-> (stk_addr_o == ADDR_W'(sp_o + 1'b1)));
  // R3
  pop_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !load_i) |-> (stk_addr_o == sp_o));
endmodule

// File: tb/stk_addr_unit_bench.sv
`timescale 1ns/1ps
module stk_addr_unit_bench;
  typedef struct {
    string      tag;
    logic [7:0] sp;
    logic [7:0] stk;
    logic [7:0] reg_a;
    logic       err;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0, load = 1'b0;
  logic [7:0] ldata = 8'h00;
  logic [2:0] idx = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [7:0] stk_addr, reg_addr, sp;
  logic       perr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [7:0] sp_m;

  always #2.5 clk = ~clk;

  stk_addr_unit u_stk_addr_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .load_i      (load),
    .load_data_i (ldata),
    .reg_idx_i   (idx),
    .bank_sel_i  (bank),
    .stk_addr_o  (stk_addr),
    .reg_addr_o  (reg_addr),
    .sp_o        (sp),
    .push_err_o  (perr)
  );

  task automatic cmp8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, queue expected outputs, advance model
  task automatic step(string tag, bit pu, bit po, bit ld, logic [7:0] d,
                      logic [2:0] ix, logic [1:0] bk);
    exp_t e;
    @(negedge clk);
    push = pu; pop = po; load = ld; ldata = d; idx = ix; bank = bk;
    e.tag   = tag;
    e.sp    = sp_m;
    e.stk   = (pu && !po && !ld) ? sp_m + 8'd1 : sp_m;
    e.reg_a = 8'(int'(bk) * 8 + int'(ix));
    e.err   = pu && po && !ld;
    q.push_back(e);
    if (ld)             sp_m = d;
    else if (pu && !po) sp_m = sp_m + 8'd1;
    else if (po && !pu) sp_m = sp_m - 8'd1;
  endtask

  // monitor: compare queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp8(e.tag, "sp", sp, e.sp);
        cmp8(e.tag, "stk_addr", stk_addr, e.stk);
        cmp8(e.tag, "reg_addr", reg_addr, e.reg_a);
        cmp8(e.tag, "push_err", {7'd0, perr}, {7'd0, e.err});
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sp_m = 8'h07;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset value
    step("R1", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    // R2: first push lands at 08h
    step("R2", 1, 0, 0, 8'h00, 3'd1, 2'd0);
    step("R2", 1, 0, 0, 8'h00, 3'd2, 2'd1);
    step("R2", 1, 0, 0, 8'h00, 3'd3, 2'd2);
    // R8: idle holds
    step("R8", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R8", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    // R3: pops
    step("R3", 0, 1, 0, 8'h00, 3'd4, 2'd3);
    step("R3", 0, 1, 0, 8'h00, 3'd5, 2'd0);
    // R5: push and pop together
    step("R5", 1, 1, 0, 8'h00, 3'd6, 2'd1);
    step("R5", 1, 1, 0, 8'h00, 3'd7, 2'd2);
    // R6: load over push, pop and both
    step("R6", 1, 0, 1, 8'hFF, 3'd0, 2'd0);
    step("R4", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    // R4: wrap on push at FFh
    step("R4", 1, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R4", 0, 1, 0, 8'h00, 3'd0, 2'd0);
    step("R4", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R6", 1, 1, 1, 8'h00, 3'd0, 2'd0);
    // R4: wrap on pop at 00h
    step("R4", 0, 1, 0, 8'h00, 3'd0, 2'd0);
    step("R6", 0, 1, 1, 8'h5A, 3'd0, 2'd0);
    step("R9", 1, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R9", 0, 1, 0, 8'h00, 3'd0, 2'd0);
    // R7: sweep every bank and index
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) begin
        step("R7", 0, 0, 0, 8'h00, 3'(i), 2'(b));
      end
    end
    // R1: asynchronous reset mid-run
    step("R8", 1, 0, 0, 8'h00, 3'd0, 2'd0);
    @(negedge clk);
    push = 1'b0;
    #1;
    rst_n = 1'b0;
    sp_m  = 8'h07;
    #1;
    cmp8("R1", "sp_async", sp, 8'h07);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R2", 1, 0, 0, 8'h00, 3'd0, 2'd0);
    step("R8", 0, 0, 0, 8'h00, 3'd0, 2'd0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule